// File: doc/BRIEF.md
# Master Clock Ratio and Clock-Loss Detector

This block sits in the master-clock domain of an audio converter's digital front end. It counts master-clock cycles between successive rising edges of the word (frame) clock. From that count it works out which of the supported master-to-frame ratios is in use and which sampling-speed band (normal, double or quad) applies. Downstream logic uses the ratio code and the speed band to set up its clock dividers and filters. The block holds that logic in reset through a single hold output whenever the clocks cannot be trusted.

A free-running reference clock watches the master clock. If no activity reaches the reference domain for a fixed number of reference cycles, the master clock is taken as lost. The same reference clock times each frame, which separates 256x and 384x at normal speed from the same ratios at double speed. The boundary is a frame rate equivalent to 64 kHz. The active-low power-down pin resets everything at once and asynchronously. After it is released, the hold output stays asserted until both clocks are running and a ratio has been confirmed. Frame timing starts on a word-clock rising edge.

The control sequencer has five named states:
- IDLE: after reset. On the first rising edge it goes to MEASURE.
- MEASURE: the first full frame is being counted. On the next rising edge it goes to CONFIRM.
- CONFIRM: on each rising edge, two consecutive frame counts within the tolerance and a supported ratio send it to LOCKED. Otherwise it stays in CONFIRM.
- LOCKED: on each rising edge, a count outside the tolerance or an unsupported ratio sends it back to CONFIRM.
- STALLED: reached from MEASURE, CONFIRM or LOCKED when the word clock stalls. It is also reached from any state when the master clock is lost. On the next rising edge it goes to MEASURE.

Top module: `clk_ratio_detect`

## Requirements
- R1: While pdn_n is low, reset_hold is 1, locked is 0, ratio_code is 0 and speed_mode is 0, taking effect without waiting for a clock edge.
- R2: After pdn_n rises, reset_hold stays 1 and locked stays 0 until the word clock is toggling and a ratio has been confirmed.
- R3: The frame length is counted in master-clock cycles from one word-clock rising edge to the next. A count within ±2 of a nominal ratio is reported on ratio_code while locked, using this encoding: 1=128, 2=192, 3=256, 4=384, 5=512, 6=768, 7=1152. Any other count is unsupported, and ratio_code reads 0 whenever the block is not locked.
- R4: With auto_mode=1, speed_mode is set as follows:
  - 2 (quad) for the 128 and 192 ratios.
  - 1 (double) for 256 and 384 when a frame lasts fewer than REF_FAST_LIM reference cycles.
  - 0 (normal) for 256 and 384 otherwise, and for 512, 768 and 1152.
- R5: With auto_mode=0, speed_mode is always 0 (normal). Only the 256, 384, 512, 768 and 1152 ratios can lock.
- R6: Two conditions are needed to lock: two consecutive frame counts that differ by at most 2, and a supported ratio. Frames that alternate by more than 2 counts keep locked at 0.
- R7: If more than 2048 master-clock cycles pass without a word-clock rising edge, locked falls and reset_hold rises. The block locks again by itself once the word clock returns.
- R8: If no master-clock activity is seen for 64 reference-clock cycles, reset_hold rises. The block locks again by itself once the master clock returns.
- R9: reset_hold is 0 only when all three hold: pdn_n is high, the master clock is present, and locked is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; the counting domain |
| ref_clk | input | 1 | Free-running reference clock |
| lrck | input | 1 | Word (frame) clock, asynchronous to both clocks |
| pdn_n | input | 1 | Active-low power-down; asynchronous reset |
| auto_mode | input | 1 | 1: speed taken from measurement; 0: normal speed forced |
| ratio_code | output | 3 | Detected ratio code (see R3), 0 when unlocked |
| speed_mode | output | 2 | 0 normal, 1 double, 2 quad |
| reset_hold | output | 1 | Holds the downstream datapath in reset |
| locked | output | 1 | A ratio is confirmed and tracked |

## Verification
A sequencer stuck in the wrong state shows at the ports as a locked flag that never rises, or one that stays high after the word clock has stopped. The stalled case shows within 2049 master cycles of the last edge; a failure to lock shows within three frames. A wrong ratio table or a wrong speed decision shows as a wrong ratio_code or speed_mode within three frames of a clock change. A broken master-clock watchdog shows as reset_hold staying low 64 reference cycles after the master clock stops. Each of these is driven by a dedicated stimulus and compared against a behavioural model once the outputs have settled. Every reference cycle in power-down is also compared.

// File: rtl/ckdet_pkg.sv
package ckdet_pkg;

    typedef enum logic [2:0] {
        RC_NONE = 3'd0,
        RC_128  = 3'd1,
        RC_192  = 3'd2,
        RC_256  = 3'd3,
        RC_384  = 3'd4,
        RC_512  = 3'd5,
        RC_768  = 3'd6,
        RC_1152 = 3'd7
    } ratio_e;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2
    } speed_e;

    function automatic int unsigned ratio_nominal(input ratio_e c);
        unique case (c)
            RC_128:  return 128;
            RC_192:  return 192;
            RC_256:  return 256;
            RC_384:  return 384;
            RC_512:  return 512;
            RC_768:  return 768;
            RC_1152: return 1152;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ratio_classify.sv
module ratio_classify
    import ckdet_pkg::*;
#(
    parameter int          CNT_W = 13,
    parameter int unsigned TOL   = 2
) (
    input  logic [CNT_W-1:0] period_i,
    input  logic             manual_i,
    output ratio_e           code_o
);
    logic [31:0] p32;

    always_comb begin
        p32    = 32'(period_i);
        code_o = RC_NONE;
        for (int k = 1; k < 8; k++) begin
            if ((p32 + TOL >= ratio_nominal(ratio_e'(3'(k)))) &&
                (p32 <= ratio_nominal(ratio_e'(3'(k))) + TOL))
                code_o = ratio_e'(3'(k));
        end
        if (manual_i && (code_o == RC_128 || code_o == RC_192))
            code_o = RC_NONE;
    end
endmodule

// File: rtl/ref_watch.sv
module ref_watch #(
    parameter int unsigned REF_STOP     = 64,
    parameter int unsigned REF_FAST_LIM = 192
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic beat_i,
    input  logic lrck_i,
    output logic mclk_lost_o,
    output logic frame_fast_o
);
    localparam int IDLE_W = $clog2(REF_STOP) + 1;
    localparam int REF_W  = $clog2(REF_FAST_LIM) + 2;

    logic              tog_s, tog_d, lr_s, lr_d, primed_q;
    logic [IDLE_W-1:0] idle_q;
    logic [REF_W-1:0]  per_q;
    logic              lr_rise;

    cdc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_tog (
        .clk(ref_clk), .rst_n(rst_n), .d(beat_i), .q(tog_s));
    cdc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_lr (
        .clk(ref_clk), .rst_n(rst_n), .d(lrck_i), .q(lr_s));

    assign lr_rise = lr_s & ~lr_d;

    // master-clock activity watchdog
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_d       <= 1'b0;
            idle_q      <= '0;
            mclk_lost_o <= 1'b1;
        end else begin
            tog_d <= tog_s;
            if (tog_s != tog_d) begin
                idle_q      <= '0;
                mclk_lost_o <= 1'b0;
            end else begin
                if (idle_q != IDLE_W'(REF_STOP)) idle_q <= idle_q + 1'b1;
                if (idle_q == IDLE_W'(REF_STOP - 1)) mclk_lost_o <= 1'b1;
            end
        end
    end

    // frame duration in reference cycles
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_d         <= 1'b0;
            per_q        <= '0;
            primed_q     <= 1'b0;
            frame_fast_o <= 1'b0;
        end else begin
            lr_d <= lr_s;
            if (lr_rise) begin
                per_q        <= '0;
                primed_q     <= 1'b1;
                frame_fast_o <= primed_q && (per_q < REF_W'(REF_FAST_LIM - 1));
            end else if (per_q != '1) begin
                per_q <= per_q + 1'b1;
            end
        end
    end

    assert_lost_after_quiet_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(mclk_lost_o) |-> $past(idle_q) == IDLE_W'(REF_STOP - 1));

    assert_toggle_clears_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (tog_s != tog_d) |=> !mclk_lost_o);
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import ckdet_pkg::*;
#(
    parameter int unsigned STOP_LIMIT = 2048,
    parameter int unsigned TOL        = 2,
    parameter int unsigned MDIV_BIT   = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lrck_s,
    input  logic   auto_mode,
    input  logic   fast_s,
    input  logic   lost_s,
    output logic   beat_o,
    output logic   locked_o,
    output ratio_e code_o,
    output speed_e speed_o
);
    localparam int CNT_W = $clog2(STOP_LIMIT + 1) + 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_MEASURE, ST_CONFIRM, ST_LOCKED, ST_STALLED
    } state_e;

    state_e             state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, prev_q, period, diff;
    logic [MDIV_BIT:0]  div_q;
    logic               lr_d, rise, stall, accept;
    ratio_e             code_c;
    speed_e             speed_c;

    assign rise   = lrck_s & ~lr_d;
    assign period = cnt_q + 1'b1;
    assign stall  = (cnt_q == CNT_W'(STOP_LIMIT));
    assign diff   = (period > prev_q) ? (period - prev_q) : (prev_q - period);
    assign accept = (diff <= CNT_W'(TOL)) && (code_c != RC_NONE);
    assign beat_o = div_q[MDIV_BIT];

    ratio_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
        .period_i(period), .manual_i(!auto_mode), .code_o(code_c));

    always_comb begin
        speed_c = SPD_NORMAL;
        if (auto_mode) begin
            unique case (code_c)
                RC_128, RC_192: speed_c = SPD_QUAD;
                RC_256, RC_384: speed_c = fast_s ? SPD_DOUBLE : SPD_NORMAL;
                default:        speed_c = SPD_NORMAL;
            endcase
        end
    end

    // counting datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_d   <= 1'b0;
            cnt_q  <= '0;
            prev_q <= '0;
            div_q  <= '0;
        end else begin
            lr_d  <= lrck_s;
            div_q <= div_q + 1'b1;
            if (rise) begin
                cnt_q  <= '0;
                prev_q <= period;
            end else if (!stall) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (lost_s) begin
            state_d = ST_STALLED;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_STALLED: if (rise) state_d = ST_MEASURE;
                ST_MEASURE: begin
                    if (stall)     state_d = ST_STALLED;
                    else if (rise) state_d = ST_CONFIRM;
                end
                ST_CONFIRM: begin
                    if (stall)               state_d = ST_STALLED;
                    else if (rise && accept) state_d = ST_LOCKED;
                end
                ST_LOCKED: begin
                    if (stall)                state_d = ST_STALLED;
                    else if (rise && !accept) state_d = ST_CONFIRM;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_o <= 1'b0;
            code_o   <= RC_NONE;
            speed_o  <= SPD_NORMAL;
        end else begin
            locked_o <= (state_d == ST_LOCKED);
            if (state_d != ST_LOCKED) begin
                code_o  <= RC_NONE;
                speed_o <= SPD_NORMAL;
            end else if (rise) begin
                code_o  <= code_c;
                speed_o <= speed_c;
            end
        end
    end

    assert_locked_has_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> code_o != RC_NONE);

    assert_quad_only_low_ratio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && speed_o == SPD_QUAD) |-> (code_o == RC_128 || code_o == RC_192));

    assert_manual_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(locked_o) && $past(!auto_mode)) |-> speed_o == SPD_NORMAL);

    assert_lock_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(rise));

    assert_stall_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && stall) |=> !locked_o);
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
    import ckdet_pkg::*;
#(
    parameter int unsigned STOP_LIMIT   = 2048,
    parameter int unsigned TOL          = 2,
    parameter int unsigned REF_STOP     = 64,
    parameter int unsigned REF_FAST_LIM = 192,
    parameter int unsigned MDIV_BIT     = 2
) (
    input  logic       mclk,
    input  logic       ref_clk,
    input  logic       lrck,
    input  logic       pdn_n,
    input  logic       auto_mode,
    output logic [2:0] ratio_code,
    output logic [1:0] speed_mode,
    output logic       reset_hold,
    output logic       locked
);
    logic   rst_m_n, rst_r_n;
    logic   lr_m, fast_r, fast_m, lost_r, lost_m, beat;
    ratio_e code;
    speed_e speed;

    cdc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_m (
        .clk(mclk), .rst_n(pdn_n), .d(1'b1), .q(rst_m_n));
    cdc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_r (
        .clk(ref_clk), .rst_n(pdn_n), .d(1'b1), .q(rst_r_n));

    cdc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_lr_m (
        .clk(mclk), .rst_n(rst_m_n), .d(lrck), .q(lr_m));
    cdc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_fast_m (
        .clk(mclk), .rst_n(rst_m_n), .d(fast_r), .q(fast_m));
    cdc_sync #(.STAGES(2), .RST_VAL(1'b1)) u_lost_m (
        .clk(mclk), .rst_n(rst_m_n), .d(lost_r), .q(lost_m));

    ref_watch #(.REF_STOP(REF_STOP), .REF_FAST_LIM(REF_FAST_LIM)) u_watch (
        .ref_clk(ref_clk), .rst_n(rst_r_n), .beat_i(beat), .lrck_i(lrck),
        .mclk_lost_o(lost_r), .frame_fast_o(fast_r));

    frame_fsm #(.STOP_LIMIT(STOP_LIMIT), .TOL(TOL), .MDIV_BIT(MDIV_BIT)) u_fsm (
        .clk(mclk), .rst_n(rst_m_n), .lrck_s(lr_m), .auto_mode(auto_mode),
        .fast_s(fast_m), .lost_s(lost_m), .beat_o(beat), .locked_o(locked),
        .code_o(code), .speed_o(speed));

    assign ratio_code = code;
    assign speed_mode = speed;
    assign reset_hold = !pdn_n || lost_r || !locked;

    always_ff @(posedge ref_clk) begin
        if (!pdn_n) begin
            assert_pdn_forces_hold_R1: assert (reset_hold && !locked && ratio_code == 3'd0);
        end
    end
endmodule

// File: tb/clk_ratio_detect_tb.sv
module clk_ratio_detect_tb_top;
    localparam int REF_PERIOD = 10;
    localparam int REF_LIM    = 192;

    logic       mclk, ref_clk, lrck, pdn_n, auto_mode;
    logic [2:0] ratio_code;
    logic [1:0] speed_mode;
    logic       reset_hold, locked;

    int  n_cmp = 0, n_bad = 0;
    int  half = 2, cur_ratio = 512, jit = 0, ph = 0;
    bit  mclk_run = 1, lrck_run = 0, alt = 0, done = 0;

    clk_ratio_detect dut_i (
        .mclk(mclk), .ref_clk(ref_clk), .lrck(lrck), .pdn_n(pdn_n),
        .auto_mode(auto_mode), .ratio_code(ratio_code), .speed_mode(speed_mode),
        .reset_hold(reset_hold), .locked(locked));

    initial begin
        ref_clk = 0;
        forever #(REF_PERIOD / 2) ref_clk = ~ref_clk;
    end

    initial begin
        mclk = 0;
        forever begin
            #(half);
            if (mclk_run) mclk = ~mclk;
        end
    end

    // word clock generator, frame length alternates by +/- jit
    initial begin
        lrck = 0;
        forever begin
            @(negedge mclk);
            if (lrck_run) begin
                int len;
                len = cur_ratio + (alt ? jit : -jit);
                ph++;
                if (ph >= len) begin
                    ph  = 0;
                    alt = !alt;
                end
                lrck = (ph < len / 2);
            end
        end
    end

    function automatic int exp_code(input int n, input bit aut);
        int c;
        case (n)
            128: c = 1;  192: c = 2;  256: c = 3;  384: c = 4;
            512: c = 5;  768: c = 6;  1152: c = 7;
            default: c = 0;
        endcase
        if (!aut && c < 3) c = 0;
        return c;
    endfunction

    function automatic int exp_speed(input int n, input int hp, input bit aut);
        if (!aut) return 0;
        if (n == 128 || n == 192) return 2;
        if (n == 256 || n == 384) return (n * 2 * hp < REF_LIM * REF_PERIOD) ? 1 : 0;
        return 0;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic wait_m(input int n);
        repeat (n) @(negedge mclk);
        #1;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // every reference cycle during power-down: hold high, not locked (R1)
    initial begin
        #2;
        forever begin
            @(negedge ref_clk);
            if (!pdn_n) begin
                check("R1", "pdn hold", int'(reset_hold && !locked), 1);
            end
        end
    end

    task automatic run_cfg(input string req, input int n, input int hp, input bit aut, input int j);
        int c, s, lk;
        cur_ratio = n;  half = hp;  auto_mode = aut;  jit = j;
        wait_m(6 * (n + j) + 200);
        c  = exp_code(n, aut);
        lk = (c != 0 && j <= 1) ? 1 : 0;
        s  = lk ? exp_speed(n, hp, aut) : 0;
        if (!lk) c = 0;
        check(req, $sformatf("locked n=%0d", n), int'(locked), lk);
        check(req, $sformatf("code n=%0d", n), int'(ratio_code), c);
        check(req, $sformatf("speed n=%0d", n), int'(speed_mode), s);
        check("R9", $sformatf("hold n=%0d", n), int'(reset_hold), lk ? 0 : 1);
    endtask

    initial begin
        #(REF_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        pdn_n = 1; auto_mode = 1;
        #1 pdn_n = 0;
        #(REF_PERIOD * 20);
        check("R1", "reset hold", int'(reset_hold), 1);
        check("R1", "reset locked", int'(locked), 0);
        check("R1", "reset code", int'(ratio_code), 0);
        check("R1", "reset speed", int'(speed_mode), 0);

        pdn_n = 1;
        wait_m(3000);
        check("R2", "no word clock locked", int'(locked), 0);
        check("R2", "no word clock hold", int'(reset_hold), 1);

        lrck_run = 1;
        run_cfg("R3", 512, 2, 1, 0);
        run_cfg("R4", 256, 2, 1, 0);
        run_cfg("R4", 256, 6, 1, 0);
        run_cfg("R4", 384, 2, 1, 0);
        run_cfg("R4", 128, 2, 1, 0);
        run_cfg("R4", 192, 2, 1, 0);
        run_cfg("R3", 768, 2, 1, 0);
        run_cfg("R3", 1152, 2, 1, 0);
        run_cfg("R5", 256, 2, 0, 0);
        run_cfg("R5", 128, 2, 0, 0);
        run_cfg("R3", 300, 2, 1, 0);
        run_cfg("R6", 512, 2, 1, 1);
        run_cfg("R6", 512, 2, 1, 2);
        run_cfg("R6", 512, 2, 1, 0);

        // word clock stall and return
        lrck_run = 0;
        wait_m(2600);
        check("R7", "stall locked", int'(locked), 0);
        check("R7", "stall hold", int'(reset_hold), 1);
        lrck_run = 1;
        run_cfg("R7", 512, 2, 1, 0);

        // master clock loss and return
        mclk_run = 0;
        #(REF_PERIOD * 100);
        check("R8", "mclk lost hold", int'(reset_hold), 1);
        mclk_run = 1;
        run_cfg("R8", 384, 2, 1, 0);

        // power-down while locked acts at once
        pdn_n = 0;
        #1;
        check("R1", "pdn hold now", int'(reset_hold), 1);
        check("R1", "pdn locked now", int'(locked), 0);
        check("R1", "pdn code now", int'(ratio_code), 0);
        #(REF_PERIOD * 5);
        pdn_n = 1;
        run_cfg("R2", 384, 2, 1, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule